// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a virtual address into a physical page when a translation cache misses. After a request is accepted it reads descriptors one 32-bit word at a time over a simple memory port. It starts from the supervisor root pointer or the user root pointer, walks three levels of tables, and follows at most one indirect page descriptor. Along the way it writes used and modified flags back into the descriptors. It gathers write protection from every level it visits. When the walk ends it returns the physical page base, a write-permission flag, a fault flag, a status word and the captured faulting address.

A request is taken only while the walker is idle. The walker ends every request with a one-cycle `done` pulse, and the results stay valid until the next walk finishes. A control input chooses between 4 KB and 8 KB pages for each request.

Top module: `pgwalk`

## Requirements
- R1: A request with `reqValid` high is accepted only while the walker is idle. Each walk ends with `done` high for exactly one cycle. `fault`, `physPage`, `canWrite`, `walkStatus` and `faultAddr` are valid while `done` is high and hold their values until the next walk ends.
- R2: The walk starts from `supRoot` when `reqSuper` is 1 and from `usrRoot` when it is 0.
- R3: The first word is read from the root pointer with bits 8:0 cleared, plus 4 × address bits 31:25. The second word is read from the root-level descriptor with bits 8:0 cleared, plus 4 × address bits 24:18.
- R4: A root-level or pointer-level descriptor is valid when its bits 1:0 are 2 or 3. A page descriptor is resident when bits 1:0 are 1 or 3, indirect when they are 2, and invalid when they are 0. An invalid descriptor ends the walk with a fault and causes no further read or write.
- R5: A root-level or pointer-level descriptor whose used bit (bit 3) is clear is written back to the same address with bit 3 set. No write of any kind happens when `reqDebug` is 1.
- R6: Bit 2 is the write-protect bit. If it is set at any visited level, `canWrite` is cleared. A store that meets a write-protected descriptor faults once that descriptor has been handled. A probe (`reqProbe`) sets status bit 5 when write protection was seen.
- R7: With `bigPage` at 0, the page entry is read at the pointer descriptor with bits 7:0 cleared, plus 4 × address bits 17:12, and the physical page is the descriptor with bits 11:0 cleared. With `bigPage` at 1, the entry is read at the descriptor with bits 6:0 cleared, plus 4 × address bits 17:13, and the physical page has bits 12:0 cleared.
- R8: An indirect page descriptor causes one more read, at the descriptor with bits 1:0 cleared. The word read there is used as the page descriptor, and any write-back goes to that word. If that word is not resident (including a second indirect), the walk faults.
- R9: For a store to a page without write protection, the page descriptor is written back with used (bit 3) and modified (bit 4) both set whenever either of them is clear. In every other case only a clear used bit is set.
- R10: A page descriptor with bit 7 set faults on a user access (`reqSuper` = 0).
- R11: `walkStatus` bits 1:0 hold the access size (0 byte, 1 word, 2 long), bit 2 the supervisor flag, bit 3 the code flag, and bit 4 is 1 for any non-store access. On a fault, `faultAddr` captures the request address, `physPage` is 0 and `canWrite` is 0.
- R12: `memReq` stays high, with `memAddr` and `memWe` unchanged, until `memAck` is seen. `memWe` is high for write-backs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a walk (sampled while idle) |
| reqAddr | input | 32 | Virtual address to translate |
| reqSuper | input | 1 | Supervisor access |
| reqStore | input | 1 | Store access |
| reqCode | input | 1 | Instruction fetch access |
| reqDebug | input | 1 | Debug lookup; suppresses all write-backs |
| reqProbe | input | 1 | Probe lookup; records write protection in status |
| reqSize | input | 2 | Access size: 0 byte, 1 word, 2 long |
| bigPage | input | 1 | 1 selects 8 KB pages, 0 selects 4 KB pages |
| supRoot | input | 32 | Supervisor root table pointer |
| usrRoot | input | 32 | User root table pointer |
| memReq | output | 1 | Memory transaction request |
| memWe | output | 1 | Transaction is a write |
| memAddr | output | 32 | Word address of the transaction |
| memWdata | output | 32 | Write-back data |
| memAck | input | 1 | Transaction complete; read data valid |
| memRdata | input | 32 | Read data |
| done | output | 1 | One-cycle walk completion pulse |
| fault | output | 1 | Walk ended in a fault |
| physPage | output | 32 | Physical page base |
| canWrite | output | 1 | Write permission for the page |
| walkStatus | output | 6 | Size, supervisor, code, read and write-protect-seen flags |
| faultAddr | output | 32 | Address of the last faulting request |

## Verification
The walk is run with clean descriptors, with descriptors whose used or modified flags are already set, and with descriptors whose flags are clear. This shows that write-backs happen only when they are needed and never in debug lookups. Write protection is placed at the root, pointer and page levels in turn, for both loads and stores. This tells a fault apart from a simple loss of write permission, and shows where the probe status bit is set. Other patterns cover non-zero root and pointer indexes, both page sizes at an address whose 4 KB and 8 KB slots differ, single and double indirection, and user accesses through a separate root table with an invalid supervisor root. Together they pin down address formation and root selection.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  // descriptor flag positions
  localparam int DESC_WP    = 2;
  localparam int DESC_USED  = 3;
  localparam int DESC_MOD   = 4;
  localparam int DESC_SUPER = 7;

  typedef enum logic [1:0] {
    LVL_ROOT = 2'd0,
    LVL_PTR  = 2'd1,
    LVL_PAGE = 2'd2,
    LVL_IND  = 2'd3
  } lvl_e;

  // control -> datapath strobes
  typedef struct packed {
    logic latchReq;
    logic latchDesc;
    logic accWp;
    logic finFault;
    logic finOk;
    logic useWbAddr;
    lvl_e lvl;
  } strb_t;

  // datapath -> control descriptor classification
  typedef struct packed {
    logic descValid;
    logic descIndirect;
    logic needWb;
    logic descWp;
    logic superOnly;
    logic isStore;
    logic isSuper;
  } flags_t;
endpackage

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   memAck,
  input  flags_t flags,
  output strb_t  strb,
  output logic   memReq,
  output logic   memWe,
  output logic   done
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_EVAL, ST_WRITE, ST_POST, ST_DONE
  } st_e;

  st_e  state, nextState;
  lvl_e lvl, nextLvl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      lvl   <= LVL_ROOT;
    end else begin
      state <= nextState;
      lvl   <= nextLvl;
    end
  end

  logic atPage;
  assign atPage = (lvl == LVL_PAGE) || (lvl == LVL_IND);

  always_comb begin
    strb      = '0;
    strb.lvl  = lvl;
    nextState = state;
    nextLvl   = lvl;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strb.latchReq = 1'b1;
        nextLvl       = LVL_ROOT;
        nextState     = ST_READ;
      end
      ST_READ: if (memAck) begin
        strb.latchDesc = 1'b1;
        nextState      = ST_EVAL;
      end
      ST_EVAL: begin
        if (!flags.descValid) begin
          strb.finFault = 1'b1;
          nextState     = ST_DONE;
        end else if (flags.descIndirect) begin
          nextLvl   = LVL_IND;
          nextState = ST_READ;
        end else if (flags.needWb) begin
          nextState = ST_WRITE;
        end else begin
          nextState = ST_POST;
        end
      end
      ST_WRITE: begin
        strb.useWbAddr = 1'b1;
        if (memAck) nextState = ST_POST;
      end
      ST_POST: begin
        strb.accWp = flags.descWp;
        if (flags.descWp && flags.isStore) begin
          strb.finFault = 1'b1;
          nextState     = ST_DONE;
        end else if (atPage) begin
          if (flags.superOnly && !flags.isSuper) strb.finFault = 1'b1;
          else                                   strb.finOk    = 1'b1;
          nextState = ST_DONE;
        end else begin
          nextLvl   = (lvl == LVL_ROOT) ? LVL_PTR : LVL_PAGE;
          nextState = ST_READ;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign memReq = (state == ST_READ) || (state == ST_WRITE);
  assign memWe  = (state == ST_WRITE);
  assign done   = (state == ST_DONE);
endmodule

// File: rtl/pgwalk_dpath.sv
module pgwalk_dpath
  import pgwalk_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int ROOT_IDX_W    = 7,
  parameter int PTR_IDX_W     = 7,
  parameter int SMALL_PG_BITS = 12,
  parameter int SIZE_W        = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strb_t             strb,
  output flags_t            flags,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSuper,
  input  logic              reqStore,
  input  logic              reqCode,
  input  logic              reqDebug,
  input  logic              reqProbe,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              bigPage,
  input  logic [ADDR_W-1:0] supRoot,
  input  logic [ADDR_W-1:0] usrRoot,
  input  logic [ADDR_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  output logic [ADDR_W-1:0] physPage,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              fault,
  output logic              canWrite,
  output logic [SIZE_W+3:0] walkStatus
);
  localparam int ROOT_LO     = ADDR_W - ROOT_IDX_W;
  localparam int PTR_LO      = ROOT_LO - PTR_IDX_W;
  localparam int BIG_PG_BITS = SMALL_PG_BITS + 1;
  localparam int SMALL_IDX_W = PTR_LO - SMALL_PG_BITS;
  localparam int BIG_IDX_W   = PTR_LO - BIG_PG_BITS;

  function automatic logic [ADDR_W-1:0] alignDown(input logic [ADDR_W-1:0] v, input int lsb);
    logic [ADDR_W-1:0] m;
    m = '1;
    m = m << lsb;
    return v & m;
  endfunction

  logic [ADDR_W-1:0] vaReg, rootReg, descReg, descAddrReg, fetchAddr, pageIdxOff, pageBase;
  logic              superReg, storeReg, codeReg, debugReg, probeReg, bigReg, wpAcc;
  logic [SIZE_W-1:0] sizeReg;

  // page-size variant of the page-table slot and frame base
  generate
    if (BIG_IDX_W > 0) begin : g_pgsel
      assign pageIdxOff = bigReg
        ? (ADDR_W'(vaReg[PTR_LO-1:BIG_PG_BITS]) << 2)
        : (ADDR_W'(vaReg[PTR_LO-1:SMALL_PG_BITS]) << 2);
      assign pageBase = bigReg ? alignDown(descReg, BIG_IDX_W + 2)
                               : alignDown(descReg, SMALL_IDX_W + 2);
    end
  endgenerate

  always_comb begin
    unique case (strb.lvl)
      LVL_ROOT: fetchAddr = alignDown(rootReg, ROOT_IDX_W + 2)
                          | (ADDR_W'(vaReg[ADDR_W-1:ROOT_LO]) << 2);
      LVL_PTR:  fetchAddr = alignDown(descReg, PTR_IDX_W + 2)
                          | (ADDR_W'(vaReg[ROOT_LO-1:PTR_LO]) << 2);
      LVL_PAGE: fetchAddr = pageBase | pageIdxOff;
      default:  fetchAddr = alignDown(descReg, 2);
    endcase
  end

  logic isPageLvl, setMod;
  assign isPageLvl = (strb.lvl == LVL_PAGE) || (strb.lvl == LVL_IND);
  assign setMod    = isPageLvl && storeReg && !descReg[DESC_WP];

  always_comb begin
    unique case (strb.lvl)
      LVL_ROOT, LVL_PTR: flags.descValid = descReg[1];
      LVL_PAGE:          flags.descValid = (descReg[1:0] != 2'b00);
      default:           flags.descValid = descReg[0];
    endcase
    flags.descIndirect = (strb.lvl == LVL_PAGE) && (descReg[1:0] == 2'b10);
    flags.needWb       = !debugReg && (!descReg[DESC_USED] || (setMod && !descReg[DESC_MOD]));
    flags.descWp       = descReg[DESC_WP];
    flags.superOnly    = isPageLvl && descReg[DESC_SUPER];
    flags.isStore      = storeReg;
    flags.isSuper      = superReg;
  end

  always_comb begin
    memWdata = descReg;
    memWdata[DESC_USED] = 1'b1;
    if (setMod) memWdata[DESC_MOD] = 1'b1;
  end

  assign memAddr = strb.useWbAddr ? descAddrReg : fetchAddr;

  logic wpNow;
  assign wpNow = wpAcc | strb.accWp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg <= '0; rootReg <= '0; descReg <= '0; descAddrReg <= '0;
      superReg <= 1'b0; storeReg <= 1'b0; codeReg <= 1'b0; debugReg <= 1'b0;
      probeReg <= 1'b0; bigReg <= 1'b0; sizeReg <= '0; wpAcc <= 1'b0;
      physPage <= '0; faultAddr <= '0; fault <= 1'b0; canWrite <= 1'b0;
      walkStatus <= '0;
    end else begin
      if (strb.latchReq) begin
        vaReg    <= reqAddr;
        rootReg  <= reqSuper ? supRoot : usrRoot;
        superReg <= reqSuper;
        storeReg <= reqStore;
        codeReg  <= reqCode;
        debugReg <= reqDebug;
        probeReg <= reqProbe;
        sizeReg  <= reqSize;
        bigReg   <= bigPage;
        wpAcc    <= 1'b0;
      end
      if (strb.latchDesc) begin
        descReg     <= memRdata;
        descAddrReg <= fetchAddr;
      end
      if (strb.accWp) wpAcc <= 1'b1;
      if (strb.finOk || strb.finFault)
        walkStatus <= {probeReg & wpNow, !storeReg, codeReg, superReg, sizeReg};
      if (strb.finOk) begin
        physPage <= bigReg ? alignDown(descReg, BIG_PG_BITS) : alignDown(descReg, SMALL_PG_BITS);
        canWrite <= !wpNow;
        fault    <= 1'b0;
      end
      if (strb.finFault) begin
        physPage  <= '0;
        canWrite  <= 1'b0;
        fault     <= 1'b1;
        faultAddr <= vaReg;
      end
    end
  end
endmodule

// File: rtl/pgwalk.sv
module pgwalk
  import pgwalk_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int ROOT_IDX_W    = 7,
  parameter int PTR_IDX_W     = 7,
  parameter int SMALL_PG_BITS = 12,
  parameter int SIZE_W        = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSuper,
  input  logic              reqStore,
  input  logic              reqCode,
  input  logic              reqDebug,
  input  logic              reqProbe,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              bigPage,
  input  logic [ADDR_W-1:0] supRoot,
  input  logic [ADDR_W-1:0] usrRoot,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [ADDR_W-1:0] memRdata,
  output logic              done,
  output logic              fault,
  output logic [ADDR_W-1:0] physPage,
  output logic              canWrite,
  output logic [SIZE_W+3:0] walkStatus,
  output logic [ADDR_W-1:0] faultAddr
);
  strb_t  strb;
  flags_t flags;

  pgwalk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memAck(memAck),
    .flags(flags), .strb(strb), .memReq(memReq), .memWe(memWe), .done(done)
  );

  pgwalk_dpath #(
    .ADDR_W(ADDR_W), .ROOT_IDX_W(ROOT_IDX_W), .PTR_IDX_W(PTR_IDX_W),
    .SMALL_PG_BITS(SMALL_PG_BITS), .SIZE_W(SIZE_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .flags(flags),
    .reqAddr(reqAddr), .reqSuper(reqSuper), .reqStore(reqStore), .reqCode(reqCode),
    .reqDebug(reqDebug), .reqProbe(reqProbe), .reqSize(reqSize), .bigPage(bigPage),
    .supRoot(supRoot), .usrRoot(usrRoot), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .physPage(physPage), .faultAddr(faultAddr),
    .fault(fault), .canWrite(canWrite), .walkStatus(walkStatus)
  );
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int ADDR_W        = 32,
  parameter int SMALL_PG_BITS = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic              wbUsedBit,
  input logic              done,
  input logic              fault,
  input logic [ADDR_W-1:0] physPage,
  input logic              canWrite
);
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_fault_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault) |-> (physPage == '0 && !canWrite));

  assert_page_align_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fault) |-> (physPage[SMALL_PG_BITS-1:0] == '0));

  assert_wb_used_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> wbUsedBit);

  assert_bus_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));
endmodule

bind pgwalk pgwalk_chk #(.ADDR_W(ADDR_W), .SMALL_PG_BITS(SMALL_PG_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAck(memAck),
  .memAddr(memAddr), .wbUsedBit(memWdata[pgwalk_pkg::DESC_USED]), .done(done),
  .fault(fault), .physPage(physPage), .canWrite(canWrite)
);

// File: tb/tb_pgwalk.sv
module tb_pgwalk;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        reqValid = 0, reqSuper = 0, reqStore = 0, reqCode = 0, reqDebug = 0, reqProbe = 0, bigPage = 0;
  logic [31:0] reqAddr = 0, supRoot = 32'h0, usrRoot = 32'h800;
  logic [1:0]  reqSize = 2'd2;
  logic        memReq, memWe, memAck = 1'b0, done, fault, canWrite;
  logic [31:0] memAddr, memWdata, memRdata = 0, physPage, faultAddr;
  logic [5:0]  walkStatus;

  always #5 clk = ~clk;

  pgwalk dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqSuper(reqSuper),
    .reqStore(reqStore), .reqCode(reqCode), .reqDebug(reqDebug), .reqProbe(reqProbe),
    .reqSize(reqSize), .bigPage(bigPage), .supRoot(supRoot), .usrRoot(usrRoot),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata), .done(done), .fault(fault),
    .physPage(physPage), .canWrite(canWrite), .walkStatus(walkStatus), .faultAddr(faultAddr)
  );

  // word memory covering 0x000..0xFFF, one-cycle registered response
  logic [31:0] mem [0:1023];
  int wrCount = 0;
  always @(posedge clk) begin
    memAck <= 1'b0;
    if (memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWe) begin
        if (memAddr[31:12] == 0) mem[memAddr[11:2]] <= memWdata;
        wrCount <= wrCount + 1;
      end else begin
        memRdata <= (memAddr[31:12] == 0) ? mem[memAddr[11:2]] : 32'h0;
      end
    end
  end

  int total = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0]  req;
    logic        big, sup, st, dbg, prb;
    logic [31:0] addr, rootS, rootU, ptr, page, ind, chkA, valA, chkB, valB;
    logic        flt;
    logic [31:0] phys;
    logic        wr;
    logic [5:0]  stat;
  } vec_t;

  localparam int NV = 16;
  // fields: req big sup st dbg prb addr rootS rootU ptr page ind chkA valA chkB valB flt phys wr stat
  localparam vec_t VECS [NV] = '{
    // R5 root/pointer/page used bits set on a clean load
    '{4'd5, 1'b0,1'b1,1'b0,1'b0,1'b0, 32'h5ABC, 32'h203,32'h20B,32'h402,32'h123001,32'h0, 32'h000,32'h20B, 32'h414,32'h123009, 1'b0,32'h123000,1'b1,6'h16},
    // R9 store sets used and modified
    '{4'd9, 1'b0,1'b1,1'b1,1'b0,1'b0, 32'h5ABC, 32'h20B,32'h20B,32'h40A,32'h123001,32'h0, 32'h200,32'h40A, 32'h414,32'h123019, 1'b0,32'h123000,1'b1,6'h06},
    // R6 store to write-protected page: used only, fault
    '{4'd6, 1'b0,1'b1,1'b1,1'b0,1'b0, 32'h5ABC, 32'h20B,32'h20B,32'h40A,32'h123005,32'h0, 32'h000,32'h20B, 32'h414,32'h12300D, 1'b1,32'h0,1'b0,6'h06},
    // R6 load under write-protected pointer level: no write permission
    '{4'd6, 1'b0,1'b1,1'b0,1'b0,1'b0, 32'h5ABC, 32'h20B,32'h20B,32'h40E,32'h123009,32'h0, 32'h200,32'h40E, 32'h414,32'h123009, 1'b0,32'h123000,1'b0,6'h16},
    // R6 store under write-protected root: faults before pointer level
    '{4'd6, 1'b0,1'b1,1'b1,1'b0,1'b0, 32'h5ABC, 32'h20F,32'h20B,32'h402,32'h123001,32'h0, 32'h200,32'h402, 32'h414,32'h123001, 1'b1,32'h0,1'b0,6'h06},
    // R4 invalid root descriptor
    '{4'd4, 1'b0,1'b1,1'b0,1'b0,1'b0, 32'h5ABC, 32'h200,32'h20B,32'h402,32'h123001,32'h0, 32'h200,32'h402, 32'h000,32'h200, 1'b1,32'h0,1'b0,6'h16},
    // R4 invalid page descriptor
    '{4'd4, 1'b0,1'b1,1'b0,1'b0,1'b0, 32'h5ABC, 32'h20B,32'h20B,32'h40A,32'h123000,32'h0, 32'h000,32'h20B, 32'h414,32'h123000, 1'b1,32'h0,1'b0,6'h16},
    // R8 indirect page descriptor, write-back to target word
    '{4'd8, 1'b0,1'b1,1'b0,1'b0,1'b0, 32'h5ABC, 32'h20B,32'h20B,32'h40A,32'h602,32'h777001, 32'h414,32'h602, 32'h600,32'h777009, 1'b0,32'h777000,1'b1,6'h16},
    // R7 8 KB page: slot from bits 17:13, frame bit 12 cleared
    '{4'd7, 1'b1,1'b1,1'b0,1'b0,1'b0, 32'h6ABC, 32'h20B,32'h20B,32'h40A,32'h125001,32'h0, 32'h418,32'h0, 32'h40C,32'h125009, 1'b0,32'h124000,1'b1,6'h16},
    // R5 debug lookup writes nothing
    '{4'd5, 1'b0,1'b1,1'b0,1'b1,1'b0, 32'h5ABC, 32'h203,32'h20B,32'h402,32'h123001,32'h0, 32'h000,32'h203, 32'h414,32'h123001, 1'b0,32'h123000,1'b1,6'h16},
    // R10 supervisor-only page, user access
    '{4'd10,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h5ABC, 32'h20B,32'h20B,32'h40A,32'h123089,32'h0, 32'h414,32'h123089, 32'h800,32'h20B, 1'b1,32'h0,1'b0,6'h12},
    // R2 user access uses user root (supervisor root invalid)
    '{4'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h5ABC, 32'h200,32'h203,32'h40A,32'h123009,32'h0, 32'h800,32'h20B, 32'h000,32'h200, 1'b0,32'h123000,1'b1,6'h12},
    // R6 probe records write protection
    '{4'd6, 1'b0,1'b1,1'b0,1'b0,1'b1, 32'h5ABC, 32'h20B,32'h20B,32'h40E,32'h123009,32'h0, 32'h200,32'h40E, 32'h414,32'h123009, 1'b0,32'h123000,1'b0,6'h36},
    // R8 second indirect faults
    '{4'd8, 1'b0,1'b1,1'b0,1'b0,1'b0, 32'h5ABC, 32'h20B,32'h20B,32'h40A,32'h602,32'h602, 32'h414,32'h602, 32'h600,32'h602, 1'b1,32'h0,1'b0,6'h16},
    // R9 store with used set, modified clear
    '{4'd9, 1'b0,1'b1,1'b1,1'b0,1'b0, 32'h5ABC, 32'h20B,32'h20B,32'h40A,32'h123009,32'h0, 32'h000,32'h20B, 32'h414,32'h123019, 1'b0,32'h123000,1'b1,6'h06},
    // R3 non-zero root and pointer indexes
    '{4'd3, 1'b0,1'b1,1'b0,1'b0,1'b0, 32'h02085000, 32'h203,32'h20B,32'h402,32'h123001,32'h0, 32'h004,32'h20B, 32'h208,32'h40A, 1'b0,32'h123000,1'b1,6'h16}
  };

  task automatic clearMem();
    for (int k = 0; k < 1024; k++) mem[k] = 32'h0;
  endtask

  task automatic launch(input logic [31:0] a, input logic sup, st, cd, dbg, prb, big, input logic [1:0] sz);
    @(negedge clk);
    reqAddr = a; reqSuper = sup; reqStore = st; reqCode = cd; reqDebug = dbg;
    reqProbe = prb; bigPage = big; reqSize = sz; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int w = 0; w < 200; w++) begin
      if (done) break;
      @(negedge clk);
    end
    chk("R1", "done seen", {31'h0, done}, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL R1 watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    clearMem();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "done after reset", {31'h0, done}, 32'h0);
    chk("R1", "fault after reset", {31'h0, fault}, 32'h0);
    chk("R12", "memReq after reset", {31'h0, memReq}, 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      int wr0, rIdx, pIdx, slot;
      v = VECS[i];
      tag = $sformatf("R%0d/v%0d", v.req, i);
      clearMem();
      rIdx = int'(v.addr[31:25]);
      pIdx = int'(v.addr[24:18]);
      slot = v.big ? (32'h400 + 4 * int'(v.addr[17:13])) : (32'h400 + 4 * int'(v.addr[17:12]));
      mem[rIdx] = v.rootS;
      mem[(32'h800 >> 2) + rIdx] = v.rootU;
      mem[(32'h200 >> 2) + pIdx] = v.ptr;
      mem[slot >> 2] = v.page;
      mem[32'h600 >> 2] = v.ind;
      wr0 = wrCount;
      launch(v.addr, v.sup, v.st, 1'b0, v.dbg, v.prb, v.big, 2'd2);
      chk(tag, "fault", {31'h0, fault}, {31'h0, v.flt});
      chk(tag, "physPage", physPage, v.phys);
      chk(tag, "canWrite", {31'h0, canWrite}, {31'h0, v.wr});
      chk(tag, "walkStatus (R11)", {26'h0, walkStatus}, {26'h0, v.stat});
      if (v.flt) chk("R11", "faultAddr", faultAddr, v.addr);
      @(negedge clk);
      if (i == 0) chk("R1", "done single cycle", {31'h0, done}, 32'h0);
      chk(tag, "memory word A", mem[v.chkA[11:2]], v.valA);
      chk(tag, "memory word B", mem[v.chkB[11:2]], v.valB);
      if (i == 0) chk("R5", "write-back count", wrCount - wr0, 3);
      if (i == 9) chk("R5", "debug write count", wrCount - wr0, 0);
    end

    // R11 fault status for a user byte code fetch with an invalid root
    clearMem();
    launch(32'h12345678, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
    chk("R11", "fault", {31'h0, fault}, 32'h1);
    chk("R11", "status byte/user/code/read", {26'h0, walkStatus}, 32'h18);
    chk("R11", "faultAddr", faultAddr, 32'h12345678);
    // R11 word store, supervisor, data
    launch(32'h0ABC0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1);
    chk("R11", "status word/super/store", {26'h0, walkStatus}, 32'h05);
    chk("R11", "faultAddr update", faultAddr, 32'h0ABC0000);
    chk("R11", "physPage on fault", physPage, 32'h0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule